// File: doc/BRIEF.md
# UART interrupt status controller

This block is the interrupt front end of a UART peripheral. It watches the live fill levels of the receive and transmit FIFOs and forms a status word from them. It latches status conditions and single-cycle error and timeout events into a sticky cause register. It holds an interrupt mask and drives one level-sensitive interrupt line to the system interrupt controller. Software reads the mask, the cause register and the live status word through a small address-selected read port.

The mask cannot be written directly. Software sets mask bits through a set-register select and clears them through a clear-register select. It acknowledges causes by writing ones to the cause register. The transmit-trigger condition appears at status bit 13 but is recorded in cause bit 10. The other live FIFO conditions keep the same bit position in the status word and in the cause register.

The block has no data stream, so every pin is a plain control or status signal. There is no valid/ready handshake, and a write strobe takes effect at the clock edge where it is sampled.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, the mask and the cause register read as zero and `irq` is low.
- R2: The status word is combinational on the current inputs:
  - bit 0 is `rx_level >= rx_trig_lvl`;
  - bit 1 is `rx_level == 0`;
  - bit 2 is `rx_level == FIFO_DEPTH`;
  - bit 3 is `tx_level == 0`;
  - bit 4 is `tx_level == FIFO_DEPTH`;
  - bit 13 is `tx_level >= tx_trig_lvl`;
  - all other bits are zero.
- R3: Any status bit among 4:0 that is high at a clock edge sets the cause bit at the same position after that edge. A cause bit stays set until software clears it.
- R4: Status bit 13 (transmit trigger) sets cause bit 10, not cause bit 13.
- R5: A one-cycle event pulse sets its cause bit after that edge:
  - receive overrun sets bit 5;
  - framing error sets bit 6;
  - parity error sets bit 7;
  - receive timeout sets bit 8;
  - modem status change sets bit 9;
  - transmit overrun sets bit 12.
- R6: A write with `wr_sel` = 3 (cause) clears every cause bit written as one and leaves the other bits unchanged.
- R7: If a bit is being set (by an event or a live status condition) in the same cycle that a cause write clears it, the bit ends up set.
- R8: A write with `wr_sel` = 0 ORs `wr_data[12:0]` into the mask. A write with `wr_sel` = 1 clears the mask bits written as one. The new mask is readable in the next cycle.
- R9: Writes with `wr_sel` = 2 (the mask itself) or `wr_sel` = 4 (status) change nothing. Mask bits above 12 cannot be set.
- R10: `irq` is high exactly when the registered mask AND the registered cause is nonzero.
- R11: `rd_data` returns:
  - the mask when `rd_sel` = 2;
  - the cause register when `rd_sel` = 3;
  - the status word when `rd_sel` = 4;
  - zero for any other select.
  
  Unused upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| rx_trig_lvl | input | CNT_W | Receive trigger level |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| tx_trig_lvl | input | CNT_W | Transmit trigger level |
| evt_rx_overrun | input | 1 | Receive overrun pulse |
| evt_frame_err | input | 1 | Framing error pulse |
| evt_parity_err | input | 1 | Parity error pulse |
| evt_rx_timeout | input | 1 | Receive timeout pulse |
| evt_modem_chg | input | 1 | Modem status change pulse |
| evt_tx_overrun | input | 1 | Transmit overrun pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | SEL_W | Read register select |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong bit in the cause register shows on `rd_data` with `rd_sel` = 3 at the next sample after the edge that produced it. If the mask covers that bit, `irq` shows the error in the same cycle. A corrupted mask shows up only through readback or through `irq` misbehaving for causes that are present.

Sticky-state errors are the quiet kind: a bit that fails to hold, or a clear that also wipes a bit being set in that cycle. The bench holds a reference copy of the mask and the cause register and compares it with the readback and with `irq` on every clock. It does this while live conditions, events and clears overlap, so such an error is caught within one cycle of its cause.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Cause register width (bits 12:0)
  localparam int CAUSE_W  = 13;
  localparam int NUM_EVT  = 6;
  localparam int NUM_LIVE = 5;

  // Status word positions
  localparam int ST_RX_TRIG  = 0;
  localparam int ST_RX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_EMPTY = 3;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_TX_TRIG  = 13;

  // Cause position of the transmit trigger (differs from status)
  localparam int CS_TX_TRIG = 10;

  typedef enum logic [2:0] {
    SEL_MASK_SET = 3'd0,
    SEL_MASK_CLR = 3'd1,
    SEL_MASK     = 3'd2,
    SEL_CAUSE    = 3'd3,
    SEL_STATUS   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic set_mask;
    logic clr_mask;
    logic clr_cause;
  } wr_strobe_t;

  // Event vector index -> cause bit position
  function automatic int evt_pos(input int idx);
    case (idx)
      0:       return 5;   // receive overrun
      1:       return 6;   // framing error
      2:       return 7;   // parity error
      3:       return 8;   // receive timeout
      4:       return 9;   // modem status change
      default: return 12;  // transmit overrun
    endcase
  endfunction

  // Cause bit position -> event index, -1 when no event maps there
  function automatic int evt_idx(input int pos);
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt_pos(i) == pos) return i;
    end
    return -1;
  endfunction

endpackage

// File: rtl/uirq_status.sv
module uirq_status
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5,
  parameter int DATA_W     = 32
) (
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  rx_trig_lvl,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  tx_trig_lvl,
  output logic [DATA_W-1:0] status_word
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  always_comb begin
    status_word              = '0;
    status_word[ST_RX_TRIG]  = (rx_level >= rx_trig_lvl);
    status_word[ST_RX_EMPTY] = (rx_level == '0);
    status_word[ST_RX_FULL]  = (rx_level == FULL_CNT);
    status_word[ST_TX_EMPTY] = (tx_level == '0);
    status_word[ST_TX_FULL]  = (tx_level == FULL_CNT);
    status_word[ST_TX_TRIG]  = (tx_level >= tx_trig_lvl);
  end

endmodule

// File: rtl/uirq_regsel.sv
module uirq_regsel
  import uirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [CAUSE_W-1:0] mask_q,
  input  logic [CAUSE_W-1:0] cause_q,
  input  logic [DATA_W-1:0]  status_word,
  output wr_strobe_t         strb,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int PAD_W = DATA_W - CAUSE_W;

  // Write decode: writes to the mask or status selects fall through
  always_comb begin
    strb = '0;
    if (wr_en) begin
      case (wr_sel)
        SEL_MASK_SET: strb.set_mask  = 1'b1;
        SEL_MASK_CLR: strb.clr_mask  = 1'b1;
        SEL_CAUSE:    strb.clr_cause = 1'b1;
        default:      strb = '0;
      endcase
    end
  end

  // Read mux
  always_comb begin
    case (rd_sel)
      SEL_MASK:   rd_data = {{PAD_W{1'b0}}, mask_q};
      SEL_CAUSE:  rd_data = {{PAD_W{1'b0}}, cause_q};
      SEL_STATUS: rd_data = status_word;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/uirq_mask.sv
module uirq_mask
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [CAUSE_W-1:0] bits,
  output logic [CAUSE_W-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (set_en) begin
      mask_q <= mask_q | bits;
    end else if (clr_en) begin
      mask_q <= mask_q & ~bits;
    end
  end

endmodule

// File: rtl/uirq_cause.sv
module uirq_cause
  import uirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LIVE-1:0] live_bits,
  input  logic                tx_trig_live,
  input  logic [NUM_EVT-1:0]  evt_vec,
  input  logic                clr_en,
  input  logic [CAUSE_W-1:0]  clr_bits,
  output logic [CAUSE_W-1:0]  cause_q
);

  logic [CAUSE_W-1:0] set_vec;
  logic [CAUSE_W-1:0] clr_vec;

  // Each cause bit picks its source: live flag, remapped trigger, event or none
  for (genvar b = 0; b < CAUSE_W; b++) begin : g_src
    if (b < NUM_LIVE) begin : g_live
      assign set_vec[b] = live_bits[b];
    end else if (b == CS_TX_TRIG) begin : g_ttrig
      assign set_vec[b] = tx_trig_live;
    end else if (evt_idx(b) >= 0) begin : g_evt
      assign set_vec[b] = evt_vec[evt_idx(b)];
    end else begin : g_none
      assign set_vec[b] = 1'b0;
    end
  end

  assign clr_vec = clr_en ? clr_bits : '0;

  // Setting dominates clearing within one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_vec) | set_vec;
    end
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 3,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  rx_trig_lvl,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  tx_trig_lvl,
  input  logic              evt_rx_overrun,
  input  logic              evt_frame_err,
  input  logic              evt_parity_err,
  input  logic              evt_rx_timeout,
  input  logic              evt_modem_chg,
  input  logic              evt_tx_overrun,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  logic [DATA_W-1:0]  status_word;
  logic [CAUSE_W-1:0] mask_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [NUM_EVT-1:0] evt_vec;
  logic [CAUSE_W-1:0] wr_bits;
  logic [DATA_W-CAUSE_W-1:0] unused_wr_hi;
  wr_strobe_t         strb;

  assign evt_vec = {evt_tx_overrun, evt_modem_chg, evt_rx_timeout,
                    evt_parity_err, evt_frame_err, evt_rx_overrun};
  assign wr_bits      = wr_data[CAUSE_W-1:0];
  assign unused_wr_hi = wr_data[DATA_W-1:CAUSE_W];

  uirq_status #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W)
  ) status_i (
    .rx_level    (rx_level),
    .rx_trig_lvl (rx_trig_lvl),
    .tx_level    (tx_level),
    .tx_trig_lvl (tx_trig_lvl),
    .status_word (status_word)
  );

  uirq_regsel #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) regsel_i (
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .rd_sel      (rd_sel),
    .mask_q      (mask_q),
    .cause_q     (cause_q),
    .status_word (status_word),
    .strb        (strb),
    .rd_data     (rd_data)
  );

  uirq_mask mask_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (strb.set_mask),
    .clr_en (strb.clr_mask),
    .bits   (wr_bits),
    .mask_q (mask_q)
  );

  uirq_cause cause_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .live_bits    (status_word[NUM_LIVE-1:0]),
    .tx_trig_live (status_word[ST_TX_TRIG]),
    .evt_vec      (evt_vec),
    .clr_en       (strb.clr_cause),
    .clr_bits     (wr_bits),
    .cause_q      (cause_q)
  );

  assign irq = |(mask_q & cause_q);

endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int CNT_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   rx_level,
  input logic [CNT_W-1:0]   tx_level,
  input logic [CNT_W-1:0]   tx_trig_lvl,
  input logic [NUM_EVT-1:0] evt_vec,
  input logic               wr_en,
  input logic [SEL_W-1:0]   wr_sel,
  input logic [DATA_W-1:0]  wr_data,
  input logic [CAUSE_W-1:0] mask_q,
  input logic [CAUSE_W-1:0] cause_q,
  input logic               irq
);

  logic               mask_wr;
  logic               set_wr;
  logic               clr_wr;
  logic [CAUSE_W-1:0] wbits;
  logic [CAUSE_W-1:0] keep_bits;

  assign set_wr    = wr_en && (wr_sel == SEL_W'(SEL_MASK_SET));
  assign clr_wr    = wr_en && (wr_sel == SEL_W'(SEL_MASK_CLR));
  assign mask_wr   = set_wr || clr_wr;
  assign wbits     = wr_data[CAUSE_W-1:0];
  assign keep_bits = (wr_en && (wr_sel == SEL_W'(SEL_CAUSE))) ? (cause_q & ~wbits) : cause_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (mask_q == '0 && cause_q == '0 && !irq)
        else $error("reset state not clear");
    end
  end

  // R5 and R7: an event always lands, even against a clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assert_evt_sets_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[i] |=> cause_q[evt_pos(i)]);
  end

  assert_cause_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(keep_bits)) == $past(keep_bits)));

  assert_rx_empty_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> cause_q[ST_RX_EMPTY]);

  assert_tx_trig_remap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level >= tx_trig_lvl) |=> cause_q[CS_TX_TRIG]);

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mask_q & $past(wbits)) == $past(wbits)));

  assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((mask_q & $past(wbits)) == '0));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & cause_q) != '0) |-> irq);

endmodule

bind uart_irq_ctrl uirq_checker #(
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .CNT_W  (CNT_W)
) checker_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_level    (rx_level),
  .tx_level    (tx_level),
  .tx_trig_lvl (tx_trig_lvl),
  .evt_vec     (evt_vec),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .mask_q      (mask_q),
  .cause_q     (cause_q),
  .irq         (irq)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CW         = 5;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b1;
  logic [CW-1:0] rx_level = 5'd2, rx_trig_lvl = 5'd8;
  logic [CW-1:0] tx_level = 5'd3, tx_trig_lvl = 5'd8;
  logic e_ovr = 0, e_frm = 0, e_par = 0, e_tmo = 0, e_mdm = 0, e_tov = 0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = 3'd0;
  logic [31:0]   wr_data = '0;
  logic [2:0]    rd_sel = 3'd7;
  logic [31:0]   rd_data;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic ready = 1'b0;
  logic done  = 1'b0;

  // Reference state
  logic [31:0] m_mask, m_cause, m_set, m_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_level(rx_level), .rx_trig_lvl(rx_trig_lvl),
    .tx_level(tx_level), .tx_trig_lvl(tx_trig_lvl),
    .evt_rx_overrun(e_ovr), .evt_frame_err(e_frm), .evt_parity_err(e_par),
    .evt_rx_timeout(e_tmo), .evt_modem_chg(e_mdm), .evt_tx_overrun(e_tov),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] ref_status();
    logic [31:0] s = '0;
    s[0]  = (rx_level >= rx_trig_lvl);
    s[1]  = (rx_level == 0);
    s[2]  = (rx_level == DEPTH);
    s[3]  = (tx_level == 0);
    s[4]  = (tx_level == DEPTH);
    s[13] = (tx_level >= tx_trig_lvl);
    return s;
  endfunction

  function automatic logic [31:0] ref_read(input logic [2:0] sel);
    case (sel)
      3'd2:    return m_mask;
      3'd3:    return m_cause;
      3'd4:    return ref_status();
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask  = '0;
      m_cause = '0;
    end else begin
      m_set = ref_status() & 32'h1F;
      if (ref_status() & 32'h2000) m_set = m_set | 32'h400;
      if (e_ovr) m_set = m_set | 32'h020;
      if (e_frm) m_set = m_set | 32'h040;
      if (e_par) m_set = m_set | 32'h080;
      if (e_tmo) m_set = m_set | 32'h100;
      if (e_mdm) m_set = m_set | 32'h200;
      if (e_tov) m_set = m_set | 32'h1000;
      m_clr = (wr_en && wr_sel == 3'd3) ? wr_data : 32'd0;
      if (wr_en && wr_sel == 3'd0) m_mask = m_mask | (wr_data & 32'h1FFF);
      if (wr_en && wr_sel == 3'd1) m_mask = m_mask & ~wr_data;
      m_cause = (m_cause & ~m_clr) | m_set;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (ready && !done) begin
      case (rd_sel)
        3'd2:    chk("R8 mask readback", rd_data, ref_read(rd_sel));
        3'd3:    chk("R3 cause readback", rd_data, ref_read(rd_sel));
        3'd4:    chk("R2 status readback", rd_data, ref_read(rd_sel));
        default: chk("R11 idle readback", rd_data, ref_read(rd_sel));
      endcase
      chk("R10 irq level", {31'd0, irq}, {31'd0, |(m_mask & m_cause)});
    end
  end

  task automatic peek(input logic [2:0] sel, output logic [31:0] v);
    @(posedge clk); #2;
    rd_sel = sel;
    @(negedge clk); #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle_levels();
    rx_level = 5'd2; rx_trig_lvl = 5'd8; tx_level = 5'd3; tx_trig_lvl = 5'd8;
  endtask

  task automatic pulse(input int idx);
    @(posedge clk); #2;
    case (idx)
      0: e_ovr = 1'b1;
      1: e_frm = 1'b1;
      2: e_par = 1'b1;
      3: e_tmo = 1'b1;
      4: e_mdm = 1'b1;
      default: e_tov = 1'b1;
    endcase
    @(posedge clk); #2;
    {e_ovr, e_frm, e_par, e_tmo, e_mdm, e_tov} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog (R1..sequence) actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #1 rst_n = 1'b0;
    // R1: reset state
    peek(3'd3, v); chk("R1 cause in reset", v, 32'h0);
    peek(3'd2, v); chk("R1 mask in reset", v, 32'h0);
    chk("R1 irq in reset", {31'd0, irq}, 32'h0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    ready = 1'b1;

    // R11: unmapped and write-only selects read zero
    peek(3'd0, v); chk("R11 read sel0", v, 32'h0);
    peek(3'd1, v); chk("R11 read sel1", v, 32'h0);
    peek(3'd5, v); chk("R11 read sel5", v, 32'h0);
    peek(3'd7, v); chk("R11 read sel7", v, 32'h0);

    // R2: status patterns
    peek(3'd4, v); chk("R2 idle status", v, 32'h0);
    rx_level = 5'd16; rx_trig_lvl = 5'd4; tx_level = 5'd5; tx_trig_lvl = 5'd5;
    peek(3'd4, v); chk("R2 rx full, tx at trigger", v, 32'h2005);
    rx_level = 5'd0; rx_trig_lvl = 5'd1; tx_level = 5'd16; tx_trig_lvl = 5'd20;
    peek(3'd4, v); chk("R2 rx empty, tx full", v, 32'h12);

    // R3/R4: everything seen so far is latched
    idle_levels();
    peek(3'd3, v); chk("R3 R4 latched causes", v, 32'h417);

    // R6: full clear
    wr(3'd3, 32'hFFFF_FFFF);
    peek(3'd3, v); chk("R6 clear all", v, 32'h0);

    // R3: sticky after one-cycle condition
    @(posedge clk); #2; rx_level = 5'd16;
    @(posedge clk); #2; idle_levels();
    peek(3'd3, v); chk("R3 sticky after brief full", v, 32'h005);
    wr(3'd3, 32'h1FFF);

    // R4: transmit trigger at status 13, cause 10
    tx_level = 5'd8;
    peek(3'd4, v); chk("R4 status trigger position", v, 32'h2000);
    idle_levels();
    peek(3'd3, v); chk("R4 cause trigger position", v, 32'h400);

    // R6: partial clear
    pulse(0); pulse(2);
    peek(3'd3, v); chk("R6 before partial clear", v, 32'h4A0);
    wr(3'd3, 32'h080);
    peek(3'd3, v); chk("R6 partial clear", v, 32'h420);
    wr(3'd3, 32'h1FFF);

    // R5: each event to its own bit
    for (int i = 0; i < 6; i++) begin
      logic [31:0] ev_exp;
      ev_exp = (i == 5) ? 32'h1000 : (32'h20 << i);
      pulse(i);
      peek(3'd3, v); chk("R5 event bit", v, ev_exp);
      wr(3'd3, 32'h1FFF);
    end

    // R7: set beats clear in the same cycle
    @(posedge clk); #2;
    rx_level = 5'd0; e_frm = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'h042;
    @(posedge clk); #2;
    e_frm = 1'b0; wr_en = 1'b0; idle_levels();
    peek(3'd3, v); chk("R7 set wins over clear", v, 32'h042);

    // R8: mask set and clear
    wr(3'd0, 32'h0A0);
    wr(3'd0, 32'h001);
    peek(3'd2, v); chk("R8 mask set OR", v, 32'h0A1);
    wr(3'd1, 32'h020);
    peek(3'd2, v); chk("R8 mask clear", v, 32'h081);

    // R9: ignored writes
    wr(3'd0, 32'hFFFF_E000);
    peek(3'd2, v); chk("R9 mask upper bits", v, 32'h081);
    wr(3'd2, 32'h1FFF);
    peek(3'd2, v); chk("R9 direct mask write", v, 32'h081);
    wr(3'd4, 32'hFFFF_FFFF);
    peek(3'd4, v); chk("R9 status write", v, 32'h0);
    peek(3'd3, v); chk("R9 cause untouched", v, 32'h042);

    // R10: interrupt line
    @(negedge clk); #1; chk("R10 no overlap", {31'd0, irq}, 32'h0);
    pulse(2);
    @(negedge clk); #1; chk("R10 masked parity", {31'd0, irq}, 32'h1);
    wr(3'd3, 32'h080);
    @(negedge clk); #1; chk("R10 after clear", {31'd0, irq}, 32'h0);
    wr(3'd0, 32'h040);
    @(negedge clk); #1; chk("R10 mask enables frame", {31'd0, irq}, 32'h1);
    wr(3'd1, 32'h040);
    @(negedge clk); #1; chk("R10 mask disables frame", {31'd0, irq}, 32'h0);

    @(posedge clk); #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule